// File: doc/BRIEF.md
# Programmable Burst Line-Fill Sequencer

This block paces a four-word cache line fill that is read from an external synchronous secondary cache. A host asks for a fill by presenting the line number of an aligned 16-byte line together with a request strobe. The block then runs a burst of four 32-bit beats. During the burst it drives the read enable of the cache SRAM and the index of the word being read, which it also presents as a full byte address. For each beat it raises a ready pulse toward the CPU side once that beat's programmed latency has elapsed.

A 2-bit timing setting selects the delay to the first beat (2 or 3 bus clocks) and the spacing of the next three beats (1 or 2 bus clocks). This gives the x-y-y-y shapes 2-1-1-1, 3-1-1-1, 2-2-2-2 and 3-2-2-2. A done pulse marks the fourth beat. A busy output holds off new requests until the burst has ended. Tag lookup, the hit/miss decision and the SRAM array itself are outside this block.

Top module: `burst_fill_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `busy`, `sram_oe`, `beat_ready` and `fill_done` are 0 and `word_idx` is 0.
- R2: A request is accepted at a clock edge where `fill_req` is 1 and the block is idle. Cycle 1 is the cycle that follows the accepting edge. The first `beat_ready` falls in cycle 2 when `fill_cfg[0]`=0 and in cycle 3 when `fill_cfg[0]`=1.
- R3: Each of the three later beats comes 1 cycle after the previous beat when `fill_cfg[1]`=0, and 2 cycles after it when `fill_cfg[1]`=1. Encodings: 00=2-1-1-1, 01=3-1-1-1, 10=2-2-2-2, 11=3-2-2-2.
- R4: `fill_done` is 1 only in the cycle of the fourth `beat_ready`. That cycle is cycle 5, 6, 8 or 9 for settings 00, 01, 10 and 11.
- R5: In the cycle of beat k (k=0..3), `word_idx` equals k and `fill_word_addr` equals {line, k[1:0], 2'b00}, where line is the `fill_line` value captured at acceptance. Later changes of `fill_line` have no effect.
- R6: `fill_cfg` is sampled only at acceptance. Changing it during a burst does not alter that burst's timing.
- R7: `busy` and `sram_oe` are 1 from cycle 1 through the done cycle, and 0 in the cycle that follows.
- R8: A request raised during a burst and dropped before the burst ends is never accepted. A request held high through the burst is accepted at the end of the first cycle after done, so `busy` is 1 again one cycle later.
- R9: A reset in the middle of a burst returns the block to idle, with all strobes low and `word_idx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_req | input | 1 | Line fill request |
| fill_line | input | 28 | Line number (byte address bits 31:4) |
| fill_cfg | input | 2 | Timing pattern select, bit0 = slow lead, bit1 = slow follow |
| busy | output | 1 | Burst in progress, new requests held off |
| sram_oe | output | 1 | Cache SRAM read enable |
| word_idx | output | 2 | Index of the word in the line |
| fill_word_addr | output | 32 | Byte address of the current word |
| beat_ready | output | 1 | Per-beat ready pulse |
| fill_done | output | 1 | Last-beat marker |

## Verification
Every result is counted in cycles from the accepting edge. For a setting with lead L and spacing F, beat k is due in cycle L+k·F, done in cycle L+3F, and idle in the cycle after that. The bench applies inputs on falling edges. Inside each scenario it walks cycle by cycle from the accepting rising edge, and at each following falling edge it compares `beat_ready`, `fill_done`, `busy`, `sram_oe` and, on beats, the word index and address against values computed from L and F. Ignored inputs (a changed setting, a changed line, a stray request) are checked through the beat timing and address, and through `busy` staying low in later idle cycles.

// File: rtl/bfs_pkg.sv
// Shared types of the burst line-fill sequencer.
// Assumes a 2-bit timing setting: bit1 picks the slow follow-on spacing,
// bit0 picks the slow lead latency.
package bfs_pkg;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_BURST = 1'b1
    } fill_state_t;

    typedef struct packed {
        logic slow_next;
        logic slow_lead;
    } fill_cfg_t;

endpackage

// File: rtl/bfs_cfg_decode.sv
// Turns the encoded timing setting into two latencies in bus clocks.
// Assumes every latency parameter fits in LAT_W bits and is nonzero.
module bfs_cfg_decode
    import bfs_pkg::*;
#(
    parameter int LAT_W     = 2,
    parameter int LEAD_FAST = 2,
    parameter int LEAD_SLOW = 3,
    parameter int NEXT_FAST = 1,
    parameter int NEXT_SLOW = 2
) (
    input  fill_cfg_t        cfg,
    output logic [LAT_W-1:0] lead_lat,
    output logic [LAT_W-1:0] next_lat
);

    // Select the lead and follow-on latencies from the setting bits.
    always_comb begin
        lead_lat = cfg.slow_lead ? LAT_W'(LEAD_SLOW) : LAT_W'(LEAD_FAST);
        next_lat = cfg.slow_next ? LAT_W'(NEXT_SLOW) : LAT_W'(NEXT_FAST);
    end

endmodule

// File: rtl/bfs_lat_counter.sv
// Down counter that times the wait before a beat.
// On load it holds (value - 1). It reports expired in the cycle its count is 0.
// Assumes load values are at least 1.
module bfs_lat_counter #(
    parameter int LAT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             expired
);

    logic [LAT_W-1:0] cnt_q;

    // Load the new wait, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - LAT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - LAT_W'(1);
    end

    assign expired = (cnt_q == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R2

endmodule

// File: rtl/bfs_beat_counter.sv
// Counts the beats of one burst and flags the last beat.
// Assumes clear and advance never come in the same cycle.
module bfs_beat_counter #(
    parameter int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    logic [IDX_W-1:0] idx_q;

    // Step to the next word on each non-final beat, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            idx_q <= '0;
        else if (advance)
            idx_q <= idx_q + IDX_W'(1);
    end

    assign idx  = idx_q;
    assign last = (idx_q == IDX_W'(BEATS - 1));

endmodule

// File: rtl/burst_fill_seq.sv
// Burst line-fill sequencer: accepts a line request when idle, then paces
// BEATS word reads from the secondary cache with a programmable lead and
// follow-on latency. It raises one ready per beat and done on the last.
// Assumes the requester holds fill_req until it sees busy, and that the
// cache returns the data in the cycle its ready is shown.
module burst_fill_seq
    import bfs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_B    = 4,
    parameter int BEATS     = 4,
    parameter int LAT_W     = 2,
    parameter int LEAD_FAST = 2,
    parameter int LEAD_SLOW = 3,
    parameter int NEXT_FAST = 1,
    parameter int NEXT_SLOW = 2,
    localparam int IDX_W    = $clog2(BEATS),
    localparam int BYTE_W   = $clog2(WORD_B),
    localparam int LINE_W   = ADDR_W - IDX_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [1:0]        fill_cfg,
    output logic              busy,
    output logic              sram_oe,
    output logic [IDX_W-1:0]  word_idx,
    output logic [ADDR_W-1:0] fill_word_addr,
    output logic              beat_ready,
    output logic              fill_done
);

    fill_state_t       state_q;
    fill_cfg_t         cfg_q;
    fill_cfg_t         cfg_sel;
    logic [LINE_W-1:0] line_q;
    logic [LAT_W-1:0]  lead_lat;
    logic [LAT_W-1:0]  next_lat;
    logic              accept;
    logic              wait_over;
    logic              last_beat;
    logic              cnt_load;
    logic [LAT_W-1:0]  cnt_val;
    logic [IDX_W-1:0]  beat_idx;

    // Take a request only while idle.
    assign accept = (state_q == FS_IDLE) && fill_req;

    // Decode the live setting while idle, the captured one during a burst.
    assign cfg_sel = (state_q == FS_IDLE) ? fill_cfg_t'(fill_cfg) : cfg_q;

    bfs_cfg_decode #(
        .LAT_W    (LAT_W),
        .LEAD_FAST(LEAD_FAST),
        .LEAD_SLOW(LEAD_SLOW),
        .NEXT_FAST(NEXT_FAST),
        .NEXT_SLOW(NEXT_SLOW)
    ) u_decode (
        .cfg     (cfg_sel),
        .lead_lat(lead_lat),
        .next_lat(next_lat)
    );

    // A beat is ready when its wait has run out inside a burst.
    assign beat_ready = (state_q == FS_BURST) && wait_over;
    assign fill_done  = beat_ready && last_beat;

    // Restart the wait on acceptance and after each non-final beat.
    assign cnt_load = accept || (beat_ready && !last_beat);
    assign cnt_val  = accept ? lead_lat : next_lat;

    bfs_lat_counter #(
        .LAT_W(LAT_W)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .expired (wait_over)
    );

    bfs_beat_counter #(
        .BEATS(BEATS)
    ) u_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept || fill_done),
        .advance(beat_ready && !last_beat),
        .idx    (beat_idx),
        .last   (last_beat)
    );

    // Enter a burst on acceptance and leave it on the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FS_IDLE;
        else if (accept)
            state_q <= FS_BURST;
        else if (fill_done)
            state_q <= FS_IDLE;
    end

    // Capture the line number and timing setting at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            cfg_q  <= '0;
        end else if (accept) begin
            line_q <= fill_line;
            cfg_q  <= fill_cfg_t'(fill_cfg);
        end
    end

    assign busy           = (state_q == FS_BURST);
    assign sram_oe        = (state_q == FS_BURST);
    assign word_idx       = beat_idx;
    assign fill_word_addr = {line_q, beat_idx, {BYTE_W{1'b0}}};

    AST_READY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ready |-> (busy && sram_oe)); // R7

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (word_idx == IDX_W'(BEATS - 1))); // R4

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !busy); // R8

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !accept) |=> (cfg_q == $past(cfg_q))); // R6

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ready && !fill_done) |=> (word_idx == $past(word_idx) + IDX_W'(1))); // R5

endmodule

// File: tb/tb_burst_fill_seq.sv
module tb_burst_fill_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_req = 1'b0;
    logic [27:0] fill_line = '0;
    logic [1:0]  fill_cfg = 2'b00;
    logic        busy, sram_oe, beat_ready, fill_done;
    logic [1:0]  word_idx;
    logic [31:0] fill_word_addr;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    burst_fill_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fill_req      (fill_req),
        .fill_line     (fill_line),
        .fill_cfg      (fill_cfg),
        .busy          (busy),
        .sram_oe       (sram_oe),
        .word_idx      (word_idx),
        .fill_word_addr(fill_word_addr),
        .beat_ready    (beat_ready),
        .fill_done     (fill_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, {28'd0, busy, sram_oe, beat_ready, fill_done}, 32'd0);
        chk(req, {30'd0, word_idx}, 32'd0);
    endtask

    // One burst: accept, then check each cycle against lead/follow timing.
    task automatic run_burst(input logic [1:0] cfg, input logic [27:0] line,
                             input logic [1:0] cfg_mid, input bit keep_req,
                             input bit stray_req);
        int lead, fol, total, beat;
        bit exp_rdy;
        lead  = cfg[0] ? 3 : 2;
        fol   = cfg[1] ? 2 : 1;
        total = lead + 3 * fol;
        beat  = 0;
        @(negedge clk);
        fill_req = 1'b1; fill_cfg = cfg; fill_line = line;
        @(posedge clk);
        for (int n = 1; n <= total; n++) begin
            @(negedge clk);
            fill_req  = keep_req || (stray_req && n == 2);
            fill_cfg  = cfg_mid;
            fill_line = ~line;
            exp_rdy = (n >= lead) && (((n - lead) % fol) == 0);
            chk("R7 busy", {31'd0, busy}, 32'd1);
            chk("R7 sram_oe", {31'd0, sram_oe}, 32'd1);
            chk(n == lead ? "R2 first beat" : "R3 beat spacing", {31'd0, beat_ready}, {31'd0, exp_rdy});
            chk("R4 done", {31'd0, fill_done}, {31'd0, exp_rdy && beat == 3});
            if (exp_rdy) begin
                chk("R5 word_idx", {30'd0, word_idx}, beat);
                chk("R5 word addr", fill_word_addr, {line, beat[1:0], 2'b00});
                beat++;
            end
        end
        chk("R4 beat count", beat, 4);
        @(negedge clk);
        chk("R7 idle after done", {30'd0, busy, sram_oe}, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fill_req = 1'b0;
        @(negedge clk);
        chk_idle("R1 reset state");
        rst_n = 1'b1;
    endtask

    task automatic t_patterns();
        run_burst(2'b00, 28'h1234567, 2'b00, 0, 0);
        run_burst(2'b01, 28'hABCDEF0, 2'b01, 0, 0);
        run_burst(2'b10, 28'h0F0F0F0, 2'b10, 0, 0);
        run_burst(2'b11, 28'hFFFFFFF, 2'b11, 0, 0);
    endtask

    task automatic t_cfg_change();
        run_burst(2'b00, 28'h5555555, 2'b11, 0, 0); // R6 fast burst, slow cfg applied mid-way
        run_burst(2'b11, 28'h2AAAAAA, 2'b00, 0, 0); // R6 slow burst, fast cfg applied mid-way
    endtask

    task automatic t_stray_request();
        run_burst(2'b10, 28'h0000001, 2'b10, 0, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 stray request ignored", {31'd0, busy}, 32'd0);
        end
    endtask

    task automatic t_held_request();
        run_burst(2'b01, 28'h7654321, 2'b00, 1, 0);
        @(negedge clk);
        chk("R8 held request accepted", {31'd0, busy}, 32'd1);
        chk("R8 restart index", {30'd0, word_idx}, 32'd0);
        fill_req = 1'b0;
        do_reset();
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        fill_req = 1'b1; fill_cfg = 2'b11; fill_line = 28'h0ABCDEF;
        repeat (5) @(negedge clk);
        fill_req = 1'b0;
        chk("R9 in burst before reset", {31'd0, busy}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R9 reset mid-burst");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R9 stays idle");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk_idle("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after reset");
        t_patterns();
        t_cfg_change();
        t_stray_request();
        t_held_request();
        t_mid_reset();
        run_burst(2'b00, 28'h0000000, 2'b01, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule